// File: doc/BRIEF.md
# I/O Window Port Decoder for an 8-bit Expansion Card

This block is the selection and data-steering logic of an 8-bit expansion-bus I/O card. The card claims a fixed block of 32 consecutive I/O ports, 300h to 31Fh. The block takes the ten address lines, the DMA address-enable line and the two active-low I/O strobes. It produces 32 active-low port selects, active-low enables for the write path and the read path of the card's bidirectional data buffer, and a direction signal for that buffer.

It also offers a split pair of selects on one chosen port. One select is for reads only and one is for writes only, so an input-only device and an output-only device can share a single address. An internal 8-bit output register sits on one chosen port. It captures the bus data when the write strobe ends, and it is driven back toward the system bus only during a matched read of that port. When both strobes are low at once, both buffer paths are blocked and a clash flag is raised.

All bus inputs are registered once on the clock. Every output follows from those registered values, so each output reflects the bus as it was sampled at the previous rising edge. The buffer is modelled as enable and direction outputs, not as tri-state pins.

Top module: `isa_io_window`

## Requirements
- R1: No port select is low unless address-enable is low and bits 9..5 of the address are 11000b (addresses 300h to 31Fh). Address 320h, address 2FFh, address 116h and any cycle with address-enable high leave all 32 selects high.
- R2: Inside the window, exactly one select is low, and its index is address bits 4..0. For example, 316h drives select 22 low and leaves the other 31 high. Every output reflects the inputs sampled at the previous rising clock edge.
- R3: The write-path enable is low exactly when the window matches, the write strobe is low and the read strobe is high.
- R4: The read-path enable is low exactly when the window matches, the read strobe is low and the write strobe is high. The direction output is 1 (toward the system bus) exactly when the read-path enable is low.
- R5: When the window matches and both strobes are low, both buffer enables and both split selects stay high and the clash flag is 1. Otherwise the clash flag is 0.
- R6: For the split port (default 22), the read-only select is low only during a matched, non-clashing read of that port. The write-only select is low only during a matched, non-clashing write of that port.
- R7: The output register (port DATA_PORT, default 22) loads the data sampled while the write strobe was low, on the cycle where the write strobe is first seen high again. The port must have been selected and the read strobe high at that time. Writes to other ports, writes outside the window and writes with address-enable high leave it unchanged.
- R8: The system-side data output is valid (valid flag 1) and carries the register value only during a matched read of DATA_PORT. Otherwise the valid flag is 0 and the data is 0.
- R9: Synchronous reset (active high) forces all selects, both enables and both split selects high, the clash flag to 0 and the output register to 0, whatever the address inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | I/O address lines |
| bus_aen | input | 1 | DMA address-enable; high blocks all decoding |
| bus_rd_n | input | 1 | Active-low I/O read strobe |
| bus_wr_n | input | 1 | Active-low I/O write strobe |
| bus_data | input | 8 | System data bus toward the card |
| port_sel_n | output | 32 | Active-low port selects, index = address bits 4..0 |
| wbuf_en_n | output | 1 | Active-low write-path buffer enable |
| rbuf_en_n | output | 1 | Active-low read-path buffer enable |
| rd_dir | output | 1 | Buffer direction, 1 = toward system bus |
| strobe_clash | output | 1 | Both strobes low during a matched cycle |
| split_rd_n | output | 1 | Read-only select of the split port |
| split_wr_n | output | 1 | Write-only select of the split port |
| card_data | output | 8 | Output register contents, toward the card |
| sys_data_out | output | 8 | Data returned toward the system bus |
| sys_data_oe | output | 1 | Valid flag for sys_data_out |

## Verification
The decode carries no history apart from the single input stage and the output register. A wrong window compare or a wrong index shows up on the select vector one cycle after the address is applied. A bad capture condition in the output register stays hidden until the port is read back. The bench therefore follows every stray write, such as writes to a neighbouring port, writes with address-enable high and writes during a clash, with a read of the register port. A corrupted register then appears on the system-side data within two cycles.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

    localparam int ADDR_W    = 10;
    localparam int DATA_W    = 8;
    localparam int PORT_BITS = 5;
    localparam int NPORTS    = 1 << PORT_BITS;
    localparam int TAG_W     = ADDR_W - PORT_BITS;
    localparam int BANK_BITS = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              aen;
        logic              rd_n;
        logic              wr_n;
        logic [DATA_W-1:0] data;
    } bus_smp_t;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2,
        XF_CLASH = 2'd3
    } xfer_t;

    function automatic bus_smp_t idle_sample();
        bus_smp_t s;
        s.addr = '0;
        s.aen  = 1'b1;
        s.rd_n = 1'b1;
        s.wr_n = 1'b1;
        s.data = '0;
        return s;
    endfunction

    function automatic xfer_t classify(input logic rd_n, input logic wr_n);
        case ({rd_n, wr_n})
            2'b01:   return XF_READ;
            2'b10:   return XF_WRITE;
            2'b00:   return XF_CLASH;
            default: return XF_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/isa_bus_sampler.sv
module isa_bus_sampler
    import isa_win_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_smp_t d,
    output bus_smp_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= idle_sample();
        else     q <= d;
    end
endmodule

// File: rtl/isa_window_match.sv
module isa_window_match
    import isa_win_pkg::*;
#(
    parameter logic [TAG_W-1:0] BASE_TAG = 5'b11000
) (
    input  logic [TAG_W-1:0] tag,
    input  logic             aen,
    output logic             match_n
);
    always_comb begin
        match_n = 1'b1;
        if (!aen && (tag == BASE_TAG)) match_n = 1'b0;
    end
endmodule

// File: rtl/isa_port_decoder.sv
module isa_port_decoder
    import isa_win_pkg::*;
(
    input  logic                 en_n,
    input  logic [PORT_BITS-1:0] idx,
    output logic [NPORTS-1:0]    sel_n
);
    localparam int BANK_SIZE = 1 << BANK_BITS;
    localparam int NBANK     = NPORTS / BANK_SIZE;
    localparam int HI_W      = PORT_BITS - BANK_BITS;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_en;
        assign bank_en = !en_n && (idx[PORT_BITS-1:BANK_BITS] == HI_W'(b));
        for (genvar j = 0; j < BANK_SIZE; j++) begin : g_out
            assign sel_n[b*BANK_SIZE + j] =
                !(bank_en && (idx[BANK_BITS-1:0] == BANK_BITS'(j)));
        end
    end
endmodule

// File: rtl/isa_buffer_ctrl.sv
module isa_buffer_ctrl
    import isa_win_pkg::*;
(
    input  logic match_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic split_sel_n,
    output logic wbuf_en_n,
    output logic rbuf_en_n,
    output logic rd_dir,
    output logic clash,
    output logic split_rd_n,
    output logic split_wr_n
);
    xfer_t kind;

    always_comb begin
        kind       = classify(rd_n, wr_n);
        wbuf_en_n  = 1'b1;
        rbuf_en_n  = 1'b1;
        clash      = 1'b0;
        split_rd_n = 1'b1;
        split_wr_n = 1'b1;
        if (!match_n) begin
            case (kind)
                XF_WRITE: begin
                    wbuf_en_n  = 1'b0;
                    split_wr_n = split_sel_n;
                end
                XF_READ: begin
                    rbuf_en_n  = 1'b0;
                    split_rd_n = split_sel_n;
                end
                XF_CLASH: clash = 1'b1;
                default: ;
            endcase
        end
        rd_dir = !rbuf_en_n;
    end
endmodule

// File: rtl/isa_out_reg.sv
module isa_out_reg
    import isa_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cur_wr_n,
    input  logic              cur_rd_n,
    input  logic              next_wr_n,
    input  logic [DATA_W-1:0] cur_data,
    input  logic              port_sel_n,
    input  logic              rbuf_en_n,
    output logic [DATA_W-1:0] card_data,
    output logic [DATA_W-1:0] sys_data_out,
    output logic              sys_data_oe
);
    logic capture;

    assign capture = !cur_wr_n && next_wr_n && cur_rd_n && !port_sel_n;

    always_ff @(posedge clk) begin
        if (rst)          card_data <= '0;
        else if (capture) card_data <= cur_data;
    end

    always_comb begin
        sys_data_oe  = !rbuf_en_n && !port_sel_n;
        sys_data_out = sys_data_oe ? card_data : '0;
    end
endmodule

// File: rtl/isa_io_window.sv
module isa_io_window
    import isa_win_pkg::*;
#(
    parameter logic [TAG_W-1:0] BASE_TAG   = 5'b11000,
    parameter int               DATA_PORT  = 22,
    parameter int               SPLIT_PORT = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_aen,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [DATA_W-1:0] bus_data,
    output logic [NPORTS-1:0] port_sel_n,
    output logic              wbuf_en_n,
    output logic              rbuf_en_n,
    output logic              rd_dir,
    output logic              strobe_clash,
    output logic              split_rd_n,
    output logic              split_wr_n,
    output logic [DATA_W-1:0] card_data,
    output logic [DATA_W-1:0] sys_data_out,
    output logic              sys_data_oe
);
    bus_smp_t in_s, cur_s;
    logic     match_n;

    always_comb begin
        in_s.addr = bus_addr;
        in_s.aen  = bus_aen;
        in_s.rd_n = bus_rd_n;
        in_s.wr_n = bus_wr_n;
        in_s.data = bus_data;
    end

    isa_bus_sampler u_smp (
        .clk (clk),
        .rst (rst),
        .d   (in_s),
        .q   (cur_s)
    );

    isa_window_match #(.BASE_TAG(BASE_TAG)) u_win (
        .tag     (cur_s.addr[ADDR_W-1:PORT_BITS]),
        .aen     (cur_s.aen),
        .match_n (match_n)
    );

    isa_port_decoder u_dec (
        .en_n  (match_n),
        .idx   (cur_s.addr[PORT_BITS-1:0]),
        .sel_n (port_sel_n)
    );

    isa_buffer_ctrl u_buf (
        .match_n     (match_n),
        .rd_n        (cur_s.rd_n),
        .wr_n        (cur_s.wr_n),
        .split_sel_n (port_sel_n[SPLIT_PORT]),
        .wbuf_en_n   (wbuf_en_n),
        .rbuf_en_n   (rbuf_en_n),
        .rd_dir      (rd_dir),
        .clash       (strobe_clash),
        .split_rd_n  (split_rd_n),
        .split_wr_n  (split_wr_n)
    );

    isa_out_reg u_oreg (
        .clk          (clk),
        .rst          (rst),
        .cur_wr_n     (cur_s.wr_n),
        .cur_rd_n     (cur_s.rd_n),
        .next_wr_n    (bus_wr_n),
        .cur_data     (cur_s.data),
        .port_sel_n   (port_sel_n[DATA_PORT]),
        .rbuf_en_n    (rbuf_en_n),
        .card_data    (card_data),
        .sys_data_out (sys_data_out),
        .sys_data_oe  (sys_data_oe)
    );
endmodule

// File: rtl/isa_io_window_chk.sv
module isa_io_window_chk
    import isa_win_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_aen,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [NPORTS-1:0] port_sel_n,
    input logic              wbuf_en_n,
    input logic              rbuf_en_n,
    input logic              strobe_clash,
    input logic [DATA_W-1:0] card_data,
    input logic              sys_data_oe
);
    assert_dma_blocks_R1: assert property (@(posedge clk) disable iff (rst)
        $past(bus_aen) |-> (&port_sel_n));

    assert_one_select_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~port_sel_n));

    assert_wr_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !wbuf_en_n |-> (!$past(bus_wr_n) && $past(bus_rd_n) && !$past(bus_aen)));

    assert_rd_needs_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !rbuf_en_n |-> (!$past(bus_rd_n) && $past(bus_wr_n) && !$past(bus_aen)));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (rst)
        strobe_clash |-> (wbuf_en_n && rbuf_en_n));

    assert_reg_changes_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(card_data) |-> ($past(bus_wr_n) || $past(rst)));

    assert_oe_only_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        sys_data_oe |-> !rbuf_en_n);

    assert_reset_idle_R9: assert property (@(posedge clk)
        $past(rst) |-> ((&port_sel_n) && wbuf_en_n && rbuf_en_n && !strobe_clash));
endmodule

bind isa_io_window isa_io_window_chk u_chk (.*);

// File: tb/isa_io_window_bench.sv
module isa_io_window_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_aen = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [7:0]  bus_data = '0;
    logic [31:0] port_sel_n;
    logic        wbuf_en_n, rbuf_en_n, rd_dir, strobe_clash, split_rd_n, split_wr_n;
    logic [7:0]  card_data, sys_data_out;
    logic        sys_data_oe;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state: the inputs seen at the last edge, and the register
    int m_addr = 0, m_aen = 1, m_rd = 1, m_wr = 1, m_data = 0, m_reg = 0, m_rst = 1;

    always #10 clk = ~clk;

    isa_io_window u_isa_io_window (.*);

    function automatic bit in_win();
        return (m_aen == 0) && (m_addr >= 'h300) && (m_addr <= 'h31F);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (addr=%0h)", tag, act, exp, m_addr);
        end
    endtask

    task automatic cyc(input int a, input int aen, input int rd, input int wr,
                       input int d, input int r);
        bit mt, rdok, wrok, cl;
        int port;
        logic [31:0] exp_sel;
        bus_addr = a[9:0]; bus_aen = aen[0]; bus_rd_n = rd[0];
        bus_wr_n = wr[0]; bus_data = d[7:0]; rst = r[0];
        @(posedge clk);
        if (r != 0) begin
            m_reg = 0; m_addr = 0; m_aen = 1; m_rd = 1; m_wr = 1; m_data = 0;
        end else begin
            if (m_wr == 0 && wr == 1 && m_rd == 1 && in_win() && (m_addr % 32) == 22)
                m_reg = m_data;
            m_addr = a; m_aen = aen; m_rd = rd; m_wr = wr; m_data = d;
        end
        m_rst = r;
        @(negedge clk);
        mt   = in_win();
        port = m_addr % 32;
        rdok = mt && m_rd == 0 && m_wr == 1;
        wrok = mt && m_wr == 0 && m_rd == 1;
        cl   = mt && m_rd == 0 && m_wr == 0;
        exp_sel = '1;
        if (mt) exp_sel[port] = 1'b0;
        if (m_rst != 0) chk("R9 selects in reset", int'(port_sel_n), int'(exp_sel));
        else if (!mt)   chk("R1 selects outside window", int'(port_sel_n), int'(exp_sel));
        else            chk("R2 selects in window", int'(port_sel_n), int'(exp_sel));
        chk("R3 write enable", int'(wbuf_en_n), wrok ? 0 : 1);
        chk("R4 read enable", int'(rbuf_en_n), rdok ? 0 : 1);
        chk("R4 direction", int'(rd_dir), rdok ? 1 : 0);
        chk("R5 clash flag", int'(strobe_clash), cl ? 1 : 0);
        chk("R6 split read", int'(split_rd_n), (rdok && port == 22) ? 0 : 1);
        chk("R6 split write", int'(split_wr_n), (wrok && port == 22) ? 0 : 1);
        chk("R7 register", int'(card_data), m_reg);
        chk("R8 read valid", int'(sys_data_oe), (rdok && port == 22) ? 1 : 0);
        chk("R8 read data", int'(sys_data_out), (rdok && port == 22) ? m_reg : 0);
    endtask

    task automatic wr_port(input int a, input int aen, input int d);
        cyc(a, aen, 1, 1, d, 0);
        cyc(a, aen, 1, 0, d, 0);
        cyc(a, aen, 1, 0, d, 0);
        cyc(a, aen, 1, 1, d, 0);
        cyc(a, 1, 1, 1, 0, 0);
    endtask

    task automatic rd_port(input int a);
        cyc(a, 0, 1, 1, 0, 0);
        cyc(a, 0, 0, 1, 0, 0);
        cyc(a, 0, 1, 1, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        // R9: reset with a matching address and an active write
        cyc('h316, 0, 1, 0, 'h5A, 1);
        cyc('h316, 0, 1, 0, 'h5A, 1);
        cyc('h000, 1, 1, 1, 0, 0);
        // R7 R8: write 0xA5 to port 22 and read it back
        wr_port('h316, 0, 'hA5);
        rd_port('h316);
        // R7: neighbouring port, DMA cycle and outside window leave the register alone
        wr_port('h317, 0, 'h3C);
        wr_port('h316, 1, 'h3C);
        wr_port('h116, 0, 'h3C);
        wr_port('h336, 0, 'h3C);
        rd_port('h316);
        // R1: addresses around the window
        rd_port('h2FF);
        rd_port('h320);
        cyc('h300, 1, 0, 1, 0, 0);
        // R2 R6: every port of the window, read then write strobe
        for (int p = 0; p < 32; p++) begin
            cyc('h300 + p, 0, 0, 1, 0, 0);
            cyc('h300 + p, 0, 1, 0, p, 0);
        end
        cyc('h000, 1, 1, 1, 0, 0);
        // R5: both strobes low, then write strobe released while read low
        cyc('h316, 0, 0, 0, 'h77, 0);
        cyc('h316, 0, 0, 1, 'h77, 0);
        cyc('h316, 0, 1, 1, 0, 0);
        rd_port('h316);
        // R7: second value, then reset clears it
        wr_port('h316, 0, 'h0F);
        rd_port('h316);
        cyc('h316, 0, 0, 1, 0, 1);
        cyc('h316, 0, 0, 1, 0, 0);
        cyc('h316, 0, 1, 1, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule